// File: doc/BRIEF.md
# Two-Port Parity RAM with Split Mode

This block is a 9216-bit on-chip memory of 1024 words, each 9 bits wide. Bits 7:0 of a word carry data and bit 8 carries its even-parity bit. Two ports reach the array, and each port has its own clock, synchronous reset, address, write data, write enable, read enable, read data and parity-error flag. Larger functions such as RAM, ROM, FIFO or shift-register wrappers are built around it.

A static `packed_mode` input selects between two arrangements. With it low, the block is a true two-port RAM: both ports address all 1024 words. With it high, the array is split into two independent single-port RAMs of 512 words each. Port A owns the lower half and port B owns the upper half. The top address bit of each port is ignored in this mode.

Reads are synchronous. The write path never blocks the read path on either port. Each port can check the parity of every word it reads.

Top module: `dpram9`

## Requirements
- R1: While a port's reset is high, that port's read-data output and error flag are zero at the next clock edge.
- R2: When read enable is high at a clock edge, the word at the addressed location appears on that port's read-data output after that edge, one cycle of latency.
- R3: When read enable is low at a clock edge, that port's read-data output and error flag keep their previous values.
- R4: Write enable acts on its own, whatever the state of read enable. A read and a write on the same port in the same cycle return the word as it was before the write.
- R5: When one port writes a word in the same cycle that the other port reads that word, the read returns the old contents.
- R6: When both ports write the same word in the same cycle, the value written by port A is the one kept.
- R7: With `packed_mode` high, port A reaches words 0 to 511 and port B reaches words 512 to 1023. Address bit 9 of both ports is ignored, so the two halves never interact.
- R8: With parity checking on, the error flag is updated in the same cycle as the read data it describes. The flag is high when the XOR of all 9 bits of the word read is 1, meaning bit 8 is not the even parity of bits 7:0.
- R9: With `packed_mode` low, a word written through either port can be read through the other port at any of the 1024 addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| packed_mode | input | 1 | 0: both ports see the whole array; 1: two separate half-size RAMs |
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset of its output registers |
| addr_a | input | 10 | Port A word address |
| wdata_a | input | 9 | Port A write word (bit 8 is parity) |
| we_a | input | 1 | Port A write enable |
| re_a | input | 1 | Port A read enable |
| q_a | output | 9 | Port A read word |
| err_a | output | 1 | Port A parity error for the word on q_a |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset of its output registers |
| addr_b | input | 10 | Port B word address |
| wdata_b | input | 9 | Port B write word (bit 8 is parity) |
| we_b | input | 1 | Port B write enable |
| re_b | input | 1 | Port B read enable |
| q_b | output | 9 | Port B read word |
| err_b | output | 1 | Port B parity error for the word on q_b |

## Verification
The bench builds the block with its default values: a 10-bit address, 8 data bits and parity checking on. This gives the full 1024-word array and two 512-word halves in split mode. Both ports share one clock, so same-cycle collisions (write against write, and write against read) are well defined and can be reached deliberately. Random addresses are kept to a narrow window with a random top bit. This makes collisions and split-mode aliasing frequent, while about one write in eight carries a wrong parity bit to trigger the error flag.

// File: rtl/dpram9.sv
module dpram9 #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter bit PARITY_CHECK = 1'b1
) (
  input  logic              packed_mode,
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W:0]   wdata_a,
  input  logic              we_a,
  input  logic              re_a,
  output logic [DATA_W:0]   q_a,
  output logic              err_a,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W:0]   wdata_b,
  input  logic              we_b,
  input  logic              re_b,
  output logic [DATA_W:0]   q_b,
  output logic              err_b
);
  localparam int WORD_W = DATA_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  // each port owns one bank; a word's value is the XOR of both banks
  logic [WORD_W-1:0] bank_a [DEPTH];
  logic [WORD_W-1:0] bank_b [DEPTH];

  logic [ADDR_W-1:0] eff_a, eff_b;
  logic [WORD_W-1:0] word_a, word_b;
  logic              b_yield;

  assign eff_a   = packed_mode ? {1'b0, addr_a[ADDR_W-2:0]} : addr_a;
  assign eff_b   = packed_mode ? {1'b1, addr_b[ADDR_W-2:0]} : addr_b;
  assign b_yield = we_a && we_b && (eff_a == eff_b);
  assign word_a  = bank_a[eff_a] ^ bank_b[eff_a];
  assign word_b  = bank_a[eff_b] ^ bank_b[eff_b];

  always_ff @(posedge clk_a)
    if (we_a) bank_a[eff_a] <= wdata_a ^ bank_b[eff_a];

  always_ff @(posedge clk_b)
    if (we_b && !b_yield) bank_b[eff_b] <= wdata_b ^ bank_a[eff_b];

  always_ff @(posedge clk_a)
    if (rst_a) begin
      q_a   <= '0;
      err_a <= 1'b0;
    end else if (re_a) begin
      q_a   <= word_a;
      err_a <= PARITY_CHECK && (^word_a);
    end

  always_ff @(posedge clk_b)
    if (rst_b) begin
      q_b   <= '0;
      err_b <= 1'b0;
    end else if (re_b) begin
      q_b   <= word_b;
      err_b <= PARITY_CHECK && (^word_b);
    end

  p_hold_a_r3: assert property (@(posedge clk_a) disable iff (rst_a)
    !re_a |=> $stable(q_a) && $stable(err_a));
  p_hold_b_r3: assert property (@(posedge clk_b) disable iff (rst_b)
    !re_b |=> $stable(q_b) && $stable(err_b));
  p_flag_a_r8: assert property (@(posedge clk_a) disable iff (rst_a)
    re_a |=> err_a == (PARITY_CHECK && (^q_a)));
  p_flag_b_r8: assert property (@(posedge clk_b) disable iff (rst_b)
    re_b |=> err_b == (PARITY_CHECK && (^q_b)));
endmodule

// File: tb/dpram9_bench.sv
module dpram9_bench;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          packed_mode, rst;
  logic [AW-1:0] addr_a, addr_b;
  logic [DW:0]   wdata_a, wdata_b, q_a, q_b;
  logic          we_a, we_b, re_a, re_b, err_a, err_b;

  dpram9 u_dpram9 (
    .packed_mode(packed_mode),
    .clk_a(clk), .rst_a(rst), .addr_a(addr_a), .wdata_a(wdata_a),
    .we_a(we_a), .re_a(re_a), .q_a(q_a), .err_a(err_a),
    .clk_b(clk), .rst_b(rst), .addr_b(addr_b), .wdata_b(wdata_b),
    .we_b(we_b), .re_b(re_b), .q_b(q_b), .err_b(err_b));

  logic [DW:0] model [1<<AW];
  logic [DW:0] exp_qa, exp_qb;
  logic        exp_ea, exp_eb;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  function automatic logic [AW-1:0] map_addr(input bit port_b, input logic [AW-1:0] a,
                                             input logic pm);
    if (!pm) return a;
    return {port_b, a[AW-2:0]};
  endfunction

  function automatic logic [DW:0] good_word(input logic [DW-1:0] d);
    return {^d, d};
  endfunction

  task automatic check(input string tag);
    total++;
    if (q_a !== exp_qa || err_a !== exp_ea) begin
      bad++;
      $display("FAIL %s port A: q=%h err=%b expected q=%h err=%b", tag, q_a, err_a, exp_qa, exp_ea);
    end
    total++;
    if (q_b !== exp_qb || err_b !== exp_eb) begin
      bad++;
      $display("FAIL %s port B: q=%h err=%b expected q=%h err=%b", tag, q_b, err_b, exp_qb, exp_eb);
    end
  endtask

  task automatic step(input string tag,
                      input logic [AW-1:0] aa, input logic [DW:0] da, input logic wa, input logic ra,
                      input logic [AW-1:0] ab, input logic [DW:0] db, input logic wb, input logic rb);
    logic [AW-1:0] ma, mb;
    addr_a = aa; wdata_a = da; we_a = wa; re_a = ra;
    addr_b = ab; wdata_b = db; we_b = wb; re_b = rb;
    ma = map_addr(1'b0, aa, packed_mode);
    mb = map_addr(1'b1, ab, packed_mode);
    if (ra) begin exp_qa = model[ma]; exp_ea = ^model[ma]; end
    if (rb) begin exp_qb = model[mb]; exp_eb = ^model[mb]; end
    if (wb) model[mb] = db;
    if (wa) model[ma] = da;
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(input logic pm);
    rst = 1'b1; packed_mode = pm;
    we_a = 0; we_b = 0; re_a = 0; re_b = 0;
    repeat (2) @(negedge clk);
    exp_qa = '0; exp_qb = '0; exp_ea = 0; exp_eb = 0;
    check("R1 reset");
    rst = 1'b0;
  endtask

  task automatic random_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] aa, ab;
      logic [DW:0] da, db;
      aa = AW'($urandom % 8) | (($urandom % 2) != 0 ? AW'(1 << (AW-1)) : '0);
      ab = AW'($urandom % 8) | (($urandom % 2) != 0 ? AW'(1 << (AW-1)) : '0);
      da = good_word(DW'($urandom));
      db = good_word(DW'($urandom));
      if ($urandom % 8 == 0) da[DW] = ~da[DW];
      if ($urandom % 8 == 0) db[DW] = ~db[DW];
      step(tag, aa, da, ($urandom % 3) == 0, ($urandom % 4) != 0,
                ab, db, ($urandom % 3) == 0, ($urandom % 4) != 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    addr_a = '0; addr_b = '0; wdata_a = '0; wdata_b = '0;
    @(negedge clk);
    do_reset(1'b0);
    for (int i = 0; i < (1 << (AW-1)); i++)
      step("init", AW'(2*i), '0, 1, 0, AW'(2*i+1), '0, 1, 0);

    step("R9 write A", 10'h3F0, good_word(8'h5A), 1, 0, '0, '0, 0, 0);
    step("R9 read via B", '0, '0, 0, 0, 10'h3F0, '0, 0, 1);
    step("R2 read latency", 10'h3F0, '0, 0, 1, '0, '0, 0, 0);
    step("R3 hold A", 10'h001, '0, 0, 0, 10'h002, '0, 0, 0);
    step("R4 write with read same port", 10'h3F0, good_word(8'hC3), 1, 1, '0, '0, 0, 0);
    step("R4 write read enable low", 10'h010, good_word(8'h11), 1, 0, '0, '0, 0, 0);
    step("R5 cross read during write", 10'h3F0, good_word(8'h77), 1, 0, 10'h3F0, '0, 0, 1);
    step("R5 new value", '0, '0, 0, 0, 10'h3F0, '0, 0, 1);
    step("R6 both write", 10'h020, good_word(8'hAA), 1, 0, 10'h020, good_word(8'h55), 1, 0);
    step("R6 A wins", 10'h020, '0, 0, 1, 10'h020, '0, 0, 1);
    step("R8 bad parity write", 10'h030, {1'b1, 8'h03}, 1, 0, '0, '0, 0, 0);
    step("R8 flag raised", 10'h030, '0, 0, 1, 10'h030, '0, 0, 1);
    step("R8 flag cleared", 10'h020, '0, 0, 1, 10'h020, '0, 0, 1);
    random_run(4000, "R2 random full");

    do_reset(1'b1);
    step("R7 A ignores top bit", 10'h205, good_word(8'h3C), 1, 0, 10'h005, good_word(8'hE1), 1, 0);
    step("R7 A low half", 10'h005, '0, 0, 1, 10'h205, '0, 0, 1);
    step("R7 same addr no collision", 10'h006, good_word(8'h12), 1, 0, 10'h006, good_word(8'h34), 1, 0);
    step("R7 halves separate", 10'h006, '0, 0, 1, 10'h006, '0, 0, 1);
    random_run(4000, "R7 random split");

    do_reset(1'b0);
    random_run(2000, "R9 random full again");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule